// File: doc/BRIEF.md
# Radio Pin Controller with State-Driven Output Patterns

This block runs two banks of general-purpose pins for a radio front end, one bank for the receive side and one for the transmit side. Each pin can act as an input or as an output. An output pin takes its value from one of four sources: a value written by software, a pattern that follows the radio's activity state, or one of two groups of debug lines from the surrounding logic. Two control bits per pin pick the source.

The datapath supplies two activity flags, transmit-active and receive-active. Together they select one of four radio states. For each state the block holds one output pattern per bank. Pins handed to automatic control follow the pattern of the current state, so antenna switches and amplifier enables change with the traffic and software does not have to touch them.

Software writes and reads all configuration over a 16-bit word bus that uses byte addresses. A read of a pin-value word returns the pad inputs, not the stored software value.

Top module: `gpio_atr_ctrl`

## Requirements
- R1: After synchronous reset every stored register is zero. Every pin is an input (`*_pad_oe` = 0) with `*_pad_out` = 0, and every readable word except the two pin-value words reads 0.
- R2: A write takes effect at the rising clock edge on which `bus_wr` is 1. The word index is `bus_addr[4:1]` and `bus_addr[0]` is ignored. Words 0..7 are receive pin value, transmit pin value, receive direction, transmit direction, receive source select, transmit source select, receive debug mode, transmit debug mode. Words 8..15 are the patterns for idle, transmit-only, receive-only and full duplex, with the receive-bank pattern before the transmit-bank pattern within each state.
- R3: `*_pad_oe` equals the bank's direction register, and a bit of 1 makes that pin an output.
- R4: A pin whose direction bit is 0 drives `*_pad_out` = 0 whatever its select and debug bits are.
- R5: An output pin with debug bit 0 and select bit 0 drives the bank's software pin-value register.
- R6: An output pin with debug bit 0 and select bit 1 drives the bank's pattern for the current radio state, and the output changes in the same cycle that the activity inputs change.
- R7: The radio state is idle when neither activity input is set, transmit-only when only `tx_active` is set, receive-only when only `rx_active` is set, and full duplex when both are set.
- R8: An output pin with debug bit 1 drives its bank's `*_dbg_a` line when its select bit is 0 and its `*_dbg_b` line when its select bit is 1.
- R9: `bus_rdata` is registered. One cycle after `bus_addr` is presented it holds the addressed word. For the two pin-value words this is the bank's pad input sampled at that edge. For every other word it is the stored value.
- R10: A value written to a pin-value word is stored and drives software-controlled output pins, even though reading that word back returns the pad inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address; bits 4:1 select the word |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| tx_active | input | 1 | Transmit path active |
| rx_active | input | 1 | Receive path active |
| rx_pad_in | input | 16 | Receive-bank pad inputs |
| tx_pad_in | input | 16 | Transmit-bank pad inputs |
| rx_dbg_a | input | 16 | Receive-bank debug lines, group A |
| rx_dbg_b | input | 16 | Receive-bank debug lines, group B |
| tx_dbg_a | input | 16 | Transmit-bank debug lines, group A |
| tx_dbg_b | input | 16 | Transmit-bank debug lines, group B |
| rx_pad_out | output | 16 | Receive-bank pad output values |
| rx_pad_oe | output | 16 | Receive-bank output enables |
| tx_pad_out | output | 16 | Transmit-bank pad output values |
| tx_pad_oe | output | 16 | Transmit-bank output enables |

## Verification
The bench builds the block with its default 16-pin banks. At that width the three per-pin control bits can be laid out so that one configuration covers all eight direction, select and debug combinations in every group of eight pins. Rotating that layout moves each combination across every pin position. Each rotated layout is swept through all four activity states and several software and debug values on both banks. The full 16-word address space is small enough to write and read back completely, including writes with the ignored low address bit set.

// File: rtl/gpio_atr_pkg.sv
package gpio_atr_pkg;

    localparam int GPIO_W    = 16;
    localparam int NBANK     = 2;
    localparam int NSTATE    = 4;
    localparam int NWORD     = 16;
    localparam int WORD_IDX_W = $clog2(NWORD);
    localparam int BUS_ADDR_W = WORD_IDX_W + 1;

    // Bank index: receive bank is 0, transmit bank is 1
    localparam int BANK_RX = 0;
    localparam int BANK_TX = 1;

    // Kind of per-bank control word (word index bits 2:1, words 0..7)
    typedef enum logic [1:0] {
        KIND_VALUE = 2'd0,
        KIND_DIR   = 2'd1,
        KIND_SEL   = 2'd2,
        KIND_DBG   = 2'd3
    } ctl_kind_e;

    // Radio activity state; order matches the pattern word order
    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_TX   = 2'd1,
        RS_RX   = 2'd2,
        RS_FULL = 2'd3
    } radio_state_e;

    function automatic radio_state_e state_of(input logic tx, input logic rx);
        return radio_state_e'({rx, tx});
    endfunction

    // Decoded word address
    typedef struct packed {
        logic      is_pattern;
        logic [1:0] group;   // control kind or radio state
        logic      bank;
    } word_dec_t;

    function automatic word_dec_t decode_word(input logic [WORD_IDX_W-1:0] w);
        word_dec_t d;
        d.is_pattern = w[3];
        d.group      = w[2:1];
        d.bank       = w[0];
        return d;
    endfunction

endpackage

// File: rtl/gpio_atr_regs.sv
module gpio_atr_regs
    import gpio_atr_pkg::*;
#(
    parameter int PIN_W = GPIO_W
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [BUS_ADDR_W-1:0]             bus_addr,
    input  logic                              bus_wr,
    input  logic [PIN_W-1:0]                  bus_wdata,
    output logic [PIN_W-1:0]                  bus_rdata,
    input  logic [NBANK-1:0][PIN_W-1:0]       pad_in,
    output logic [NBANK-1:0][PIN_W-1:0]       value_q,
    output logic [NBANK-1:0][PIN_W-1:0]       dir_q,
    output logic [NBANK-1:0][PIN_W-1:0]       sel_q,
    output logic [NBANK-1:0][PIN_W-1:0]       dbg_q,
    output logic [NSTATE-1:0][NBANK-1:0][PIN_W-1:0] pat_q
);

    word_dec_t dec;
    logic      unused_addr_lsb;

    assign dec             = decode_word(bus_addr[BUS_ADDR_W-1:1]);
    assign unused_addr_lsb = bus_addr[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
            dir_q   <= '0;
            sel_q   <= '0;
            dbg_q   <= '0;
            pat_q   <= '0;
        end else if (bus_wr) begin
            if (dec.is_pattern) begin
                pat_q[dec.group][dec.bank] <= bus_wdata;
            end else begin
                unique case (ctl_kind_e'(dec.group))
                    KIND_VALUE: value_q[dec.bank] <= bus_wdata;
                    KIND_DIR:   dir_q[dec.bank]   <= bus_wdata;
                    KIND_SEL:   sel_q[dec.bank]   <= bus_wdata;
                    KIND_DBG:   dbg_q[dec.bank]   <= bus_wdata;
                endcase
            end
        end
    end

    logic [PIN_W-1:0] rd_mux;

    always_comb begin
        if (dec.is_pattern) begin
            rd_mux = pat_q[dec.group][dec.bank];
        end else begin
            unique case (ctl_kind_e'(dec.group))
                KIND_VALUE: rd_mux = pad_in[dec.bank];
                KIND_DIR:   rd_mux = dir_q[dec.bank];
                KIND_SEL:   rd_mux = sel_q[dec.bank];
                KIND_DBG:   rd_mux = dbg_q[dec.bank];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= rd_mux;
    end

    AST_DIR_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !dec.is_pattern && dec.group == 2'(KIND_DIR))
        |=> (dir_q[$past(dec.bank)] == $past(bus_wdata))) else $error("dir write lost"); // R2

    AST_PATTERN_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && dec.is_pattern)
        |=> (pat_q[$past(dec.group)][$past(dec.bank)] == $past(bus_wdata))) else $error("pattern write lost"); // R2

    AST_IDLE_BUS_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr && !$past(rst)) |=> $stable(dir_q) && $stable(sel_q) && $stable(dbg_q)) else $error("config changed without write"); // R2

endmodule

// File: rtl/gpio_atr_state.sv
module gpio_atr_state
    import gpio_atr_pkg::*;
#(
    parameter int PIN_W = GPIO_W
) (
    input  logic                                    tx_active,
    input  logic                                    rx_active,
    input  logic [NSTATE-1:0][NBANK-1:0][PIN_W-1:0] pat_q,
    output radio_state_e                            cur_state,
    output logic [NBANK-1:0][PIN_W-1:0]             cur_pattern
);

    assign cur_state = state_of(tx_active, rx_active);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank_pat
        assign cur_pattern[b] = pat_q[cur_state][b];
    end

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_atr_pkg::*;
#(
    parameter int PIN_W = GPIO_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIN_W-1:0] value,
    input  logic [PIN_W-1:0] dir,
    input  logic [PIN_W-1:0] sel,
    input  logic [PIN_W-1:0] dbg,
    input  logic [PIN_W-1:0] pattern,
    input  logic [PIN_W-1:0] dbg_a,
    input  logic [PIN_W-1:0] dbg_b,
    output logic [PIN_W-1:0] pad_out,
    output logic [PIN_W-1:0] pad_oe
);

    for (genvar i = 0; i < PIN_W; i++) begin : g_pin
        logic src;
        always_comb begin
            unique case ({dbg[i], sel[i]})
                2'b00: src = value[i];
                2'b01: src = pattern[i];
                2'b10: src = dbg_a[i];
                2'b11: src = dbg_b[i];
            endcase
        end
        assign pad_out[i] = dir[i] & src;
        assign pad_oe[i]  = dir[i];
    end

    AST_SOFTWARE_PATH: assert property (@(posedge clk) disable iff (rst)
        ((pad_out ^ value) & dir & ~sel & ~dbg) == '0) else $error("software path"); // R5

    AST_PATTERN_PATH: assert property (@(posedge clk) disable iff (rst)
        ((pad_out ^ pattern) & dir & sel & ~dbg) == '0) else $error("pattern path"); // R6

    AST_DEBUG_B_PATH: assert property (@(posedge clk) disable iff (rst)
        ((pad_out ^ dbg_b) & dir & sel & dbg) == '0) else $error("debug b path"); // R8

    AST_INPUT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (pad_out & ~pad_oe) == '0) else $error("input pin driven"); // R4

endmodule

// File: rtl/gpio_atr_ctrl.sv
module gpio_atr_ctrl
    import gpio_atr_pkg::*;
#(
    parameter int PIN_W = GPIO_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic [PIN_W-1:0]      bus_wdata,
    output logic [PIN_W-1:0]      bus_rdata,
    input  logic                  tx_active,
    input  logic                  rx_active,
    input  logic [PIN_W-1:0]      rx_pad_in,
    input  logic [PIN_W-1:0]      tx_pad_in,
    input  logic [PIN_W-1:0]      rx_dbg_a,
    input  logic [PIN_W-1:0]      rx_dbg_b,
    input  logic [PIN_W-1:0]      tx_dbg_a,
    input  logic [PIN_W-1:0]      tx_dbg_b,
    output logic [PIN_W-1:0]      rx_pad_out,
    output logic [PIN_W-1:0]      rx_pad_oe,
    output logic [PIN_W-1:0]      tx_pad_out,
    output logic [PIN_W-1:0]      tx_pad_oe
);

    logic [NBANK-1:0][PIN_W-1:0]             pad_in, dbg_a, dbg_b, pad_out, pad_oe;
    logic [NBANK-1:0][PIN_W-1:0]             value_q, dir_q, sel_q, dbg_q, cur_pattern;
    logic [NSTATE-1:0][NBANK-1:0][PIN_W-1:0] pat_q;
    radio_state_e                            cur_state;

    assign pad_in[BANK_RX] = rx_pad_in;
    assign pad_in[BANK_TX] = tx_pad_in;
    assign dbg_a[BANK_RX]  = rx_dbg_a;
    assign dbg_a[BANK_TX]  = tx_dbg_a;
    assign dbg_b[BANK_RX]  = rx_dbg_b;
    assign dbg_b[BANK_TX]  = tx_dbg_b;
    assign rx_pad_out      = pad_out[BANK_RX];
    assign tx_pad_out      = pad_out[BANK_TX];
    assign rx_pad_oe       = pad_oe[BANK_RX];
    assign tx_pad_oe       = pad_oe[BANK_TX];

    gpio_atr_regs #(.PIN_W(PIN_W)) regs_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .value_q(value_q), .dir_q(dir_q), .sel_q(sel_q), .dbg_q(dbg_q),
        .pat_q(pat_q)
    );

    gpio_atr_state #(.PIN_W(PIN_W)) state_i (
        .tx_active(tx_active), .rx_active(rx_active), .pat_q(pat_q),
        .cur_state(cur_state), .cur_pattern(cur_pattern)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        gpio_pin_mux #(.PIN_W(PIN_W)) mux_i (
            .clk(clk), .rst(rst), .value(value_q[b]), .dir(dir_q[b]),
            .sel(sel_q[b]), .dbg(dbg_q[b]), .pattern(cur_pattern[b]),
            .dbg_a(dbg_a[b]), .dbg_b(dbg_b[b]),
            .pad_out(pad_out[b]), .pad_oe(pad_oe[b])
        );
    end

    AST_FULL_DUPLEX_STATE: assert property (@(posedge clk) disable iff (rst)
        (tx_active && rx_active) |-> (cur_pattern == pat_q[NSTATE-1])) else $error("full duplex pattern"); // R7

    AST_IDLE_STATE: assert property (@(posedge clk) disable iff (rst)
        (!tx_active && !rx_active) |-> (cur_pattern == pat_q[0])) else $error("idle pattern"); // R7

    AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (rst)
        (rx_pad_oe == dir_q[BANK_RX]) && (tx_pad_oe == dir_q[BANK_TX])) else $error("oe mismatch"); // R3

endmodule

// File: tb/gpio_atr_ctrl_tb.sv
module gpio_atr_ctrl_tb_top;

    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [4:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic          tx_active = 1'b0, rx_active = 1'b0;
    logic [W-1:0]  rx_pad_in = '0, tx_pad_in = '0;
    logic [W-1:0]  rx_dbg_a = '0, rx_dbg_b = '0, tx_dbg_a = '0, tx_dbg_b = '0;
    logic [W-1:0]  rx_pad_out, rx_pad_oe, tx_pad_out, tx_pad_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gpio_atr_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_active(tx_active), .rx_active(rx_active),
        .rx_pad_in(rx_pad_in), .tx_pad_in(tx_pad_in),
        .rx_dbg_a(rx_dbg_a), .rx_dbg_b(rx_dbg_b),
        .tx_dbg_a(tx_dbg_a), .tx_dbg_b(tx_dbg_b),
        .rx_pad_out(rx_pad_out), .rx_pad_oe(rx_pad_oe),
        .tx_pad_out(tx_pad_out), .tx_pad_oe(tx_pad_oe)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input int word, input logic [W-1:0] val, input logic lsb);
        @(negedge clk);
        bus_addr  = {4'(word), lsb};
        bus_wr    = 1'b1;
        bus_wdata = val;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input int word, output logic [W-1:0] val);
        @(negedge clk);
        bus_addr = {4'(word), 1'b0};
        @(negedge clk);
        val = bus_rdata;
    endtask

    function automatic logic [W-1:0] rotl(input logic [W-1:0] v, input int k);
        return (v << k) | (v >> (W - k));
    endfunction

    function automatic logic [W-1:0] expect_out(
        input logic [W-1:0] dir, sel, dbg, val, pat, da, db);
        return dir & ((~dbg & ~sel & val) | (~dbg & sel & pat) |
                      (dbg & ~sel & da)  | (dbg & sel & db));
    endfunction

    function automatic logic [W-1:0] pat_of(input int st, input int bank);
        return W'((st * 16'h3A5B + bank * 16'h1F07 + 16'h0C21) ^ (16'h8001 << st));
    endfunction

    initial begin
        logic [W-1:0] rv;
        logic [W-1:0] cfg_dir, cfg_sel, cfg_dbg;
        logic [W-1:0] vals [2];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1 rx_oe", rx_pad_oe, '0);
        check("R1 tx_oe", tx_pad_oe, '0);
        check("R1 rx_out", rx_pad_out, '0);
        check("R1 tx_out", tx_pad_out, '0);
        for (int w = 0; w < 16; w++) begin
            bus_read(w, rv);
            check("R1 readback", rv, '0);
        end

        // Patterns for all states, both banks (R2 word order)
        for (int st = 0; st < 4; st++)
            for (int b = 0; b < 2; b++)
                bus_write(8 + 2*st + b, pat_of(st, b), 1'b0);

        // Sweep rotated configurations, states, values (R3..R8)
        for (int k = 0; k < 8; k++) begin
            cfg_dir = rotl(16'hAAAA, k);
            cfg_sel = rotl(16'hCCCC, k);
            cfg_dbg = rotl(16'hF0F0, k);
            for (int b = 0; b < 2; b++) begin
                bus_write(2 + b, b ? ~cfg_dir : cfg_dir, 1'b0);
                bus_write(4 + b, cfg_sel, 1'b0);
                bus_write(6 + b, b ? ~cfg_dbg : cfg_dbg, 1'b0);
            end
            for (int v = 0; v < 3; v++) begin
                vals[0] = W'(16'h5A3C * (v + 1) + k);
                vals[1] = ~vals[0] ^ W'(k << 3);
                bus_write(0, vals[0], 1'b0);
                bus_write(1, vals[1], 1'b0);
                rx_dbg_a = W'(16'h1234 * (v + k + 1));
                rx_dbg_b = ~rx_dbg_a;
                tx_dbg_a = rotl(rx_dbg_a, 5);
                tx_dbg_b = rotl(rx_dbg_a, 9) ^ 16'h0F0F;
                for (int st = 0; st < 4; st++) begin
                    @(negedge clk);
                    tx_active = st[0];
                    rx_active = st[1];
                    #1;
                    // R7 state decode via R6 pattern choice; R4/R5/R8 paths
                    check("R6 R7 rx_out", rx_pad_out,
                          expect_out(cfg_dir, cfg_sel, cfg_dbg, vals[0], pat_of(st, 0), rx_dbg_a, rx_dbg_b));
                    check("R6 R7 tx_out", tx_pad_out,
                          expect_out(~cfg_dir, cfg_sel, ~cfg_dbg, vals[1], pat_of(st, 1), tx_dbg_a, tx_dbg_b));
                    check("R3 rx_oe", rx_pad_oe, cfg_dir);
                    check("R3 tx_oe", tx_pad_oe, ~cfg_dir);
                end
            end
        end

        // R4: all inputs, everything else set, outputs stay 0
        bus_write(2, '0, 1'b0);
        bus_write(4, 16'hFFFF, 1'b0);
        bus_write(6, 16'h00FF, 1'b0);
        rx_dbg_a = 16'hFFFF; rx_dbg_b = 16'hFFFF;
        @(negedge clk);
        check("R4 input pins quiet", rx_pad_out, '0);

        // R2: writes with address bit 0 set still land; full readback
        rx_pad_in = 16'hBEEF;
        tx_pad_in = 16'h1357;
        for (int w = 0; w < 16; w++)
            bus_write(w, W'(16'h0101 * (w + 3) ^ 16'h6000), 1'b1);
        for (int w = 0; w < 16; w++) begin
            bus_read(w, rv);
            if (w == 0)      check("R9 rx value reads pads", rv, 16'hBEEF);
            else if (w == 1) check("R9 tx value reads pads", rv, 16'h1357);
            else             check("R2 R9 readback", rv, W'(16'h0101 * (w + 3) ^ 16'h6000));
        end

        // R10: software value drives outputs while readback shows pads
        bus_write(3, 16'hFFFF, 1'b0);
        bus_write(5, 16'h0000, 1'b0);
        bus_write(7, 16'h0000, 1'b0);
        bus_write(1, 16'hA5C3, 1'b0);
        tx_pad_in = 16'h0042;
        @(negedge clk);
        check("R10 tx_out software", tx_pad_out, 16'hA5C3);
        bus_read(1, rv);
        check("R10 tx value readback", rv, 16'h0042);

        // R9: read latency, pad sampled at the read edge
        @(negedge clk);
        bus_addr = 5'b00000;
        rx_pad_in = 16'h7777;
        check("R9 not yet updated", bus_rdata, 16'h0042);
        @(negedge clk);
        check("R9 one-cycle latency", bus_rdata, 16'h7777);

        // R1: reset mid-run clears all
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 tx_oe after reset", tx_pad_oe, '0);
        check("R1 tx_out after reset", tx_pad_out, '0);
        bus_read(9, rv);
        check("R1 pattern after reset", rv, '0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule